// File: doc/BRIEF.md
# Stack Push/Pop Microsequencer

This block is a small multi-cycle controller with its own datapath. It fetches 16-bit instruction words from a word-wide, byte-addressed memory and runs two stack instructions. It has an eight-entry register file, and register 6 serves as the stack pointer. Every instruction passes through a three-state fetch, one decode state, and then the state sequence for its opcode. Every state that touches memory raises a request and stays in that state until the memory answers with ready. Each instruction therefore costs a number of cycles that depends on the memory latency in a fixed way.

A push moves the stack pointer down by one word (2 bytes) and then stores the source register at the new top. A pop reads the word at the top of the stack into the destination register, sets the N/Z/P flags from that word, and only then moves the stack pointer up by 2. Any other opcode does nothing except advance the program counter. A one-cycle retire pulse and a free-running cycle counter come out of the block, so a user can measure how many cycles each instruction takes.

Top module: `stackSequencer`

## Requirements
- R1: While reset is held, the block raises no memory request and no retire pulse. The cycle counter reads 0, the flags read Z (3'b010), the program counter holds PC_RESET (0x0000) and register 6 holds SP_INIT (0x0100). All other registers hold 0.
- R2: The first request after reset is a read at PC_RESET. Each later instruction fetch reads at the previous fetch address plus 2.
- R3: Once a request is raised, the block keeps it raised, with address, write data and write enable unchanged, until the memory returns ready. The access completes in the cycle where request and ready are both high.
- R4: PUSH (instruction bits [15:12] = 4'hA, bits [11:9] = source register) moves register 6 down by 2. It then performs one memory write of the source register's current value at the new register 6. For a push of register 6 itself, the value written is the already decremented pointer.
- R5: POP (instruction bits [15:12] = 4'hB, bits [11:9] = destination register) reads memory at register 6 into the destination and then raises register 6 by 2.
- R6: After a POP, the flags are one-hot from the loaded word: 3'b100 if bit 15 is set, 3'b010 if the word is zero, 3'b001 otherwise. PUSH and other opcodes leave the flags unchanged.
- R7: A POP whose destination is register 6 leaves register 6 equal to the loaded word plus 2.
- R8: With a memory latency of L cycles from the first request cycle to ready inclusive, an instruction other than PUSH or POP takes L+3 cycles, PUSH takes 2L+5 and POP takes 2L+6.
- R9: The retire output is high for exactly one cycle per instruction: its last cycle. The cycle counter counts clocks since reset was released, starting at 0 in the first fetch state.
- R10: An opcode other than 4'hA or 4'hB causes no memory write and no change to the stack pointer or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| memAddr | output | 16 | Byte address of the current access (memory address register) |
| memWdata | output | 16 | Write data (memory data register) |
| memRdata | input | 16 | Read data from memory |
| memWe | output | 1 | High for a write access |
| memReq | output | 1 | Access request, held until ready |
| memReady | input | 1 | Memory completes the access this cycle |
| retire | output | 1 | Last cycle of an instruction |
| cycleCount | output | 32 | Clocks since reset release |
| ccOut | output | 3 | One-hot N/Z/P flags |

## Verification
The two hardest cases to reach from the ports are a pop into the stack pointer and a push of the stack pointer. In both, the pointer is at once the address and the data, and the state cannot be read out directly. The stimulus gets there through a program. Pops first load known words, including a negative and a zero value, into registers. The program then pushes register 6 and pops into register 6. The bench can only see the resulting pointer through the address of the next push's write, so that is where it checks it. The whole program is run twice, at two memory latencies, so the per-instruction cycle costs and the holding of requests are checked against a latency that is not fixed.

// File: rtl/stkPkg.sv
package stkPkg;
  localparam logic [3:0] OP_PUSH = 4'hA;
  localparam logic [3:0] OP_POP  = 4'hB;

  typedef enum logic [3:0] {
    S_FMAR, S_FMEM, S_FIR, S_DEC,
    S_PU_DEC, S_PU_SET, S_PU_MEM,
    S_PO_MAR, S_PO_MEM, S_PO_DR, S_PO_INC
  } seqState_t;

  typedef struct packed {
    logic marFromPc;
    logic pcStep;
    logic mdrFromMem;
    logic irFromMdr;
    logic spDown;
    logic marFromSp;
    logic mdrFromReg;
    logic regFromMdr;
    logic spUp;
  } strobes_t;
endpackage

// File: rtl/stkCtrl.sv
module stkCtrl
  import stkPkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       opcode,
  input  logic             memReady,
  output strobes_t         st,
  output logic             memReq,
  output logic             memWe,
  output logic             retire,
  output logic [CNT_W-1:0] cycleCount
);
  seqState_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_FMAR;
      cycleCount <= '0;
    end else begin
      state      <= nxt;
      cycleCount <= cycleCount + 1'b1;
    end
  end

  always_comb begin
    nxt    = state;
    st     = '0;
    memReq = 1'b0;
    memWe  = 1'b0;
    retire = 1'b0;
    case (state)
      S_FMAR: begin
        st.marFromPc = 1'b1;
        st.pcStep    = 1'b1;
        nxt          = S_FMEM;
      end
      S_FMEM: begin
        memReq = 1'b1;
        if (memReady) begin
          st.mdrFromMem = 1'b1;
          nxt           = S_FIR;
        end
      end
      S_FIR: begin
        st.irFromMdr = 1'b1;
        nxt          = S_DEC;
      end
      S_DEC: begin
        if (opcode == OP_PUSH)     nxt = S_PU_DEC;
        else if (opcode == OP_POP) nxt = S_PO_MAR;
        else begin
          retire = 1'b1;
          nxt    = S_FMAR;
        end
      end
      S_PU_DEC: begin
        st.spDown = 1'b1;
        nxt       = S_PU_SET;
      end
      S_PU_SET: begin
        st.marFromSp  = 1'b1;
        st.mdrFromReg = 1'b1;
        nxt           = S_PU_MEM;
      end
      S_PU_MEM: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memReady) begin
          retire = 1'b1;
          nxt    = S_FMAR;
        end
      end
      S_PO_MAR: begin
        st.marFromSp = 1'b1;
        nxt          = S_PO_MEM;
      end
      S_PO_MEM: begin
        memReq = 1'b1;
        if (memReady) begin
          st.mdrFromMem = 1'b1;
          nxt           = S_PO_DR;
        end
      end
      S_PO_DR: begin
        st.regFromMdr = 1'b1;
        nxt           = S_PO_INC;
      end
      S_PO_INC: begin
        st.spUp = 1'b1;
        retire  = 1'b1;
        nxt     = S_FMAR;
      end
      default: nxt = S_FMAR;
    endcase
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memWe)) else $error("request dropped"); // R3
  AST_RETIRE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    retire |=> !retire) else $error("retire longer than one cycle"); // R9
  AST_WE_IN_REQ: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq) else $error("write enable without request"); // R4
endmodule

// File: rtl/stkPath.sv
module stkPath
  import stkPkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          REG_CNT  = 8,
  parameter int          SP_IDX   = 6,
  parameter logic [15:0] PC_RESET = 16'h0000,
  parameter logic [15:0] SP_INIT  = 16'h0100,
  localparam int         RA_W     = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          st,
  input  logic              holdMem,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] marOut,
  output logic [DATA_W-1:0] mdrOut,
  output logic [3:0]        opcode,
  output logic [2:0]        ccOut
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(2);

  logic [DATA_W-1:0] pc, mar, mdr;
  logic [RA_W-1:0]   regSel;
  logic [2:0]        cc;
  logic [REG_CNT-1:0][DATA_W-1:0] rfBus;

  for (genvar g = 0; g < REG_CNT; g++) begin : gReg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN)
        q <= (g == SP_IDX) ? DATA_W'(SP_INIT) : '0;
      else if (st.regFromMdr && regSel == RA_W'(g))
        q <= mdr;
      else if (g == SP_IDX && st.spDown)
        q <= q - STEP;
      else if (g == SP_IDX && st.spUp)
        q <= q + STEP;
    end
    assign rfBus[g] = q;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc     <= DATA_W'(PC_RESET);
      mar    <= '0;
      mdr    <= '0;
      opcode <= '0;
      regSel <= '0;
      cc     <= 3'b010;
    end else begin
      if (st.pcStep) pc <= pc + STEP;
      if (st.marFromPc)      mar <= pc;
      else if (st.marFromSp) mar <= rfBus[SP_IDX];
      if (st.mdrFromMem)      mdr <= memRdata;
      else if (st.mdrFromReg) mdr <= rfBus[regSel];
      if (st.irFromMdr) begin
        opcode <= mdr[DATA_W-1 -: 4];
        regSel <= mdr[DATA_W-5 -: RA_W];
      end
      if (st.regFromMdr) begin
        if (mdr[DATA_W-1])   cc <= 3'b100;
        else if (mdr == '0)  cc <= 3'b010;
        else                 cc <= 3'b001;
      end
    end
  end

  assign marOut = mar;
  assign mdrOut = mdr;
  assign ccOut  = cc;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    st.pcStep |=> pc == $past(pc) + STEP) else $error("pc step"); // R2
  AST_SP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    st.spDown |=> rfBus[SP_IDX] == $past(rfBus[SP_IDX]) - STEP) else $error("sp down"); // R4
  AST_SP_UP: assert property (@(posedge clk) disable iff (!rstN)
    st.spUp |=> rfBus[SP_IDX] == $past(rfBus[SP_IDX]) + STEP) else $error("sp up"); // R7
  AST_CC_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(cc) == 1) else $error("flags not one-hot"); // R6
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    holdMem |=> $stable(mar) && $stable(mdr)) else $error("bus moved while waiting"); // R3
endmodule

// File: rtl/stackSequencer.sv
module stackSequencer
  import stkPkg::*;
#(
  parameter int          DATA_W   = 16,
  parameter int          REG_CNT  = 8,
  parameter logic [15:0] PC_RESET = 16'h0000,
  parameter logic [15:0] SP_INIT  = 16'h0100,
  parameter int          CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memWe,
  output logic              memReq,
  input  logic              memReady,
  output logic              retire,
  output logic [CNT_W-1:0]  cycleCount,
  output logic [2:0]        ccOut
);
  strobes_t   st;
  logic [3:0] opcode;

  stkCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .opcode(opcode), .memReady(memReady),
    .st(st), .memReq(memReq), .memWe(memWe), .retire(retire),
    .cycleCount(cycleCount)
  );

  stkPath #(
    .DATA_W(DATA_W), .REG_CNT(REG_CNT), .SP_IDX(6),
    .PC_RESET(PC_RESET), .SP_INIT(SP_INIT)
  ) uPath (
    .clk(clk), .rstN(rstN), .st(st), .holdMem(memReq && !memReady),
    .memRdata(memRdata), .marOut(memAddr), .mdrOut(memWdata),
    .opcode(opcode), .ccOut(ccOut)
  );
endmodule

// File: tb/tb_stackSequencer.sv
module tb_stackSequencer;
  localparam int NINSTR = 14;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] memAddr, memWdata, memRdata;
  logic        memWe, memReq, memReady, retire;
  logic [31:0] cycleCount;
  logic [2:0]  ccOut;

  always #5 clk = ~clk;

  stackSequencer dut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memWe(memWe), .memReq(memReq),
    .memReady(memReady), .retire(retire), .cycleCount(cycleCount),
    .ccOut(ccOut)
  );

  logic [15:0] mem [256];
  int lat = 5;
  int waitCnt = 0;
  int nChecks = 0;
  int nFail = 0;

  assign memReady = memReq && (waitCnt == lat - 1);
  assign memRdata = mem[memAddr[8:1]];

  always @(posedge clk) begin
    if (!rstN || !memReq || memReady) waitCnt <= 0;
    else waitCnt <= waitCnt + 1;
    if (rstN && memReq && memWe && memReady) mem[memAddr[8:1]] <= memWdata;
  end

  int expRet[$], expCc[$], expRd[$], expWrA[$], expWrD[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [2:0] r);
    return {op, r, 9'h0};
  endfunction

  task automatic loadImage();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    mem[0]  = enc(4'hB, 3'd1);  // POP R1 <- negative
    mem[1]  = enc(4'hB, 3'd2);  // POP R2 <- zero
    mem[2]  = enc(4'hB, 3'd3);  // POP R3 <- positive
    mem[3]  = enc(4'h3, 3'd5);  // other opcode (R10)
    mem[4]  = enc(4'hA, 3'd1);  // PUSH R1
    mem[5]  = enc(4'hA, 3'd3);  // PUSH R3
    mem[6]  = enc(4'hA, 3'd6);  // PUSH R6 (decremented pointer)
    mem[7]  = enc(4'hB, 3'd4);  // POP R4
    mem[8]  = enc(4'hB, 3'd6);  // POP R6 (R7)
    mem[9]  = enc(4'hA, 3'd2);  // PUSH R2 at loaded pointer - 2
    mem[10] = enc(4'hB, 3'd5);  // POP R5
    mem[11] = enc(4'hA, 3'd4);  // PUSH R4
    mem[128] = 16'h8001;
    mem[129] = 16'h0000;
    mem[130] = 16'h1234;
  endtask

  task automatic buildModel();
    logic [15:0] img [256];
    logic [15:0] regs [8];
    logic [15:0] pc, ir, v;
    logic [2:0]  cc;
    int cyc;
    int cost;
    for (int i = 0; i < 256; i++) img[i] = mem[i];
    for (int i = 0; i < 8; i++) regs[i] = 16'h0;
    regs[6] = 16'h0100;
    pc = 16'h0000; cc = 3'b010; cyc = 0;
    expRet.delete(); expCc.delete(); expRd.delete(); expWrA.delete(); expWrD.delete();
    for (int k = 0; k < NINSTR; k++) begin
      expRd.push_back(int'(pc));
      ir = img[pc[8:1]];
      pc = pc + 16'd2;
      if (ir[15:12] == 4'hA) begin
        regs[6] = regs[6] - 16'd2;
        expWrA.push_back(int'(regs[6]));
        expWrD.push_back(int'(regs[ir[11:9]]));
        img[regs[6][8:1]] = regs[ir[11:9]];
        cost = 2 * lat + 5;
      end else if (ir[15:12] == 4'hB) begin
        expRd.push_back(int'(regs[6]));
        v = img[regs[6][8:1]];
        regs[ir[11:9]] = v;
        cc = v[15] ? 3'b100 : (v == 16'h0) ? 3'b010 : 3'b001;
        regs[6] = regs[6] + 16'd2;
        cost = 2 * lat + 6;
      end else begin
        cost = lat + 3;
      end
      cyc = cyc + cost;
      expRet.push_back(cyc - 1);
      expCc.push_back(int'(cc));
    end
  endtask

  bit          monitoring = 1'b0;
  int          retCount = 0;
  logic        prevReq = 1'b0, prevReady = 1'b0, prevWe = 1'b0;
  logic [15:0] prevAddr = '0, prevWd = '0;

  always @(negedge clk) begin
    if (monitoring && retCount < NINSTR) begin
      if (prevReq && !prevReady) begin
        chk(memReq && memAddr == prevAddr && memWdata == prevWd && memWe == prevWe,
            "R3", "request held", {memReq, memWe, memAddr}, {1'b1, prevWe, prevAddr});
      end
      if (memReq && !memWe && !(prevReq && !prevReady)) begin
        if (expRd.size() > 0)
          chk(memAddr == 16'(expRd[0]), "R2/R5", "read address", memAddr, expRd[0]);
        else chk(1'b0, "R2", "unexpected read", memAddr, 0);
        if (expRd.size() > 0) void'(expRd.pop_front());
      end
      if (memReq && memWe && memReady) begin
        if (expWrA.size() > 0)
          chk(memAddr == 16'(expWrA[0]) && memWdata == 16'(expWrD[0]), "R4/R7",
              "push write addr,data", {memAddr, memWdata}, {16'(expWrA[0]), 16'(expWrD[0])});
        else chk(1'b0, "R10", "unexpected write", memAddr, 0);
        if (expWrA.size() > 0) begin
          void'(expWrA.pop_front());
          void'(expWrD.pop_front());
        end
      end
      if (retire) begin
        chk(expRet.size() > 0 && cycleCount == 32'(expRet[0]), "R8", "retire cycle",
            cycleCount, expRet.size() > 0 ? expRet[0] : 0);
        chk(expCc.size() > 0 && ccOut == 3'(expCc[0]), "R6", "flags at retire",
            ccOut, expCc.size() > 0 ? expCc[0] : 0);
        if (expRet.size() > 0) begin
          void'(expRet.pop_front());
          void'(expCc.pop_front());
        end
        retCount++;
      end else if (expRet.size() > 0 && cycleCount == 32'(expRet[0])) begin
        chk(1'b0, "R9", "missing retire", cycleCount, expRet[0]);
        void'(expRet.pop_front());
        void'(expCc.pop_front());
        retCount++;
      end
      prevReq = memReq; prevReady = memReady; prevWe = memWe;
      prevAddr = memAddr; prevWd = memWdata;
    end
  end

  initial begin
    rstN = 1'b0;
    for (int pass = 0; pass < 2; pass++) begin
      int guard;
      lat = (pass == 0) ? 5 : 2;
      rstN = 1'b0;
      monitoring = 1'b0;
      loadImage();
      buildModel();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!memReq && !retire, "R1", "no request/retire in reset", {memReq, retire}, 0);
      chk(cycleCount == 0, "R1", "counter in reset", cycleCount, 0);
      chk(ccOut == 3'b010, "R1", "flags in reset", ccOut, 3'b010);
      prevReq = 1'b0; prevReady = 1'b0; retCount = 0;
      rstN = 1'b1;
      @(posedge clk);
      monitoring = 1'b1;
      guard = 0;
      while (retCount < NINSTR && guard < 5000) begin
        @(negedge clk);
        guard++;
      end
      chk(guard < 5000, "R9", "watchdog", guard, 5000);
      monitoring = 1'b0;
      @(negedge clk);
      chk(expWrA.size() == 0, "R4", "all pushes written", expWrA.size(), 0);
      chk(expRet.size() == 0, "R8", "all retires seen", expRet.size(), 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule